// File: doc/BRIEF.md
# Read Strobe Polarity Selector

This block sits where read data, captured by a delayed DDR read strobe, is handed over to the system clock. The phase between that strobe and the system clock is not known in advance. At the start of every read the block therefore waits for the memory's preamble, which is the first time the memory actively pulls an idle, undriven strobe low. At that moment it looks at the system clock level sampled by the strobe edge. From that level it selects whether the synchronizing stage captures on the rising or the falling system clock edge. The chosen polarity stays fixed for the rest of the burst, and the captured words are moved into the system domain along the chosen path with a valid flag.

A read is armed by a one-cycle start request from the idle state. If no preamble arrives within a parameterised number of cycles, the block flags a timeout and keeps its previous polarity. The delay control code that travels with the delayed strobe is passed straight through without being interpreted. All strobe-related inputs are taken as already sampled into the system clock domain by the pad logic, which is not part of this block.

Top module: `strobe_pol_sel`

## Requirements
- R1: A synchronous active-high reset sets pol_sel to 0 (rising-edge capture) and sets locked, timeout_err and rd_valid to 0. The block is idle after reset.
- R2: dly_code_out equals dly_code_in at all times. It is combinational and carries no register.
- R3: A preamble event is a clock edge at which the previous sample showed strobe_drv=0 with strobe_lvl=1, and the current sample shows strobe_drv=1 with strobe_lvl=0. A start request (rd_start=1) seen while idle arms the block. An event acts only while the block is armed.
- R4: On a preamble event, pol_sel is updated at that same edge. It becomes 0 (rising) when clk_phase_smp=1 and 1 (falling) when clk_phase_smp=0.
- R5: locked rises exactly one clock after the edge that updated pol_sel.
- R6: While locked, pol_sel does not change and rd_start is ignored. locked clears at the first edge that samples strobe_drv=0, and the block then returns to idle.
- R7: Once armed, if the TIMEOUT_CYC-th edge after the arming edge still sees no event, timeout_err goes to 1, the block returns to idle and pol_sel keeps its value. timeout_err clears on the next accepted rd_start.
- R8: rd_valid marks a word only when the block was locked at the word's sampling edge and strobe_drv was 1 in both the current and the previous sample with differing strobe_lvl, which means a strobe edge was present.
- R9: With pol_sel=1, a word held on rd_data_in between two rising edges is captured at the falling edge between them and appears on rd_data_out after the second rising edge. With pol_sel=0, it appears one rising edge later. rd_valid is aligned with rd_data_out in both cases.
- R10: Strobe activity while the block is not armed or locked, including a drive-low from undriven, changes neither pol_sel nor locked and produces no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | One-cycle read start request |
| strobe_lvl | input | 1 | Sampled level of the delayed read strobe |
| strobe_drv | input | 1 | High when the memory is driving the strobe |
| clk_phase_smp | input | 1 | System clock level sampled at the strobe edge |
| dly_code_in | input | CODE_W | Delay control code accompanying the strobe |
| rd_data_in | input | DATA_W | Data word from the strobe-domain capture |
| dly_code_out | output | CODE_W | Unchanged copy of dly_code_in |
| pol_sel | output | 1 | Capture polarity: 0 rising, 1 falling |
| locked | output | 1 | Polarity fixed for the current burst |
| timeout_err | output | 1 | No preamble seen within the timeout |
| rd_data_out | output | DATA_W | Word transferred into the system domain |
| rd_valid | output | 1 | rd_data_out holds a valid word |

## Verification
The assertions assume that strobe_lvl, strobe_drv and clk_phase_smp arrive already sampled into the system domain and stay stable between rising edges. They also assume that a burst ends with the strobe released to undriven-high before the next read starts. The stimulus changes every input exactly 1 ns after a rising edge. Each burst ends with at least two released cycles. Stray strobe toggles and drive-lows are applied only while the block is idle, so every preamble the block could see has a known origin.

// File: rtl/sps_pkg.sv
package sps_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ARMED   = 2'd1,
      ST_SETTLE  = 2'd2,
      ST_LOCKED  = 2'd3
   } sps_state_e;

   localparam logic POL_RISE = 1'b0;
   localparam logic POL_FALL = 1'b1;

   // Sampled clock high at the strobe edge: the edge sits just after a rising
   // clock edge, so the falling edge is near and rising capture is safer.
   function automatic logic pick_polarity(input logic phase_high);
      return phase_high ? POL_RISE : POL_FALL;
   endfunction

endpackage

// File: rtl/sps_preamble_det.sv
module sps_preamble_det (
   input  logic clk,
   input  logic rst,
   input  logic strobe_lvl,
   input  logic strobe_drv,
   output logic pre_evt,
   output logic strobe_edge
);

   logic prev_lvl;
   logic prev_drv;

   // Idle strobe rests high through termination and is not driven.
   always_ff @(posedge clk) begin
      if (rst) begin
         prev_lvl <= 1'b1;
         prev_drv <= 1'b0;
      end else begin
         prev_lvl <= strobe_lvl;
         prev_drv <= strobe_drv;
      end
   end

   always_comb begin
      pre_evt     = !prev_drv && prev_lvl && strobe_drv && !strobe_lvl;
      strobe_edge = strobe_drv && prev_drv && (strobe_lvl != prev_lvl);
   end

endmodule

// File: rtl/sps_pol_ctrl.sv
module sps_pol_ctrl
   import sps_pkg::*;
#(
   parameter int TIMEOUT_CYC = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic rd_start,
   input  logic pre_evt,
   input  logic strobe_drv,
   input  logic clk_phase_smp,
   output logic pol_sel,
   output logic locked,
   output logic timeout_err,
   output logic armed
);

   localparam int CNT_W = $clog2((TIMEOUT_CYC > 1) ? TIMEOUT_CYC : 2);

   sps_state_e       state;
   logic [CNT_W-1:0] wait_cnt;
   logic             tmo_hit;

   generate
      if (TIMEOUT_CYC > 0) begin : g_tmo
         assign tmo_hit = (wait_cnt == CNT_W'(TIMEOUT_CYC - 1));
      end else begin : g_no_tmo
         assign tmo_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= ST_IDLE;
         wait_cnt    <= '0;
         pol_sel     <= POL_RISE;
         timeout_err <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (rd_start) begin
                  state       <= ST_ARMED;
                  wait_cnt    <= '0;
                  timeout_err <= 1'b0;
               end
            end
            ST_ARMED: begin
               if (pre_evt) begin
                  pol_sel <= pick_polarity(clk_phase_smp);
                  state   <= ST_SETTLE;
               end else if (tmo_hit) begin
                  timeout_err <= 1'b1;
                  state       <= ST_IDLE;
               end else begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            ST_SETTLE: state <= ST_LOCKED;
            ST_LOCKED: begin
               if (!strobe_drv) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign locked = (state == ST_LOCKED);
   assign armed  = (state == ST_ARMED);

endmodule

// File: rtl/sps_xfer.sv
module sps_xfer #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pol_sel,
   input  logic              locked,
   input  logic              strobe_edge,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              valid
);

   logic [DATA_W-1:0] rise_cap;
   logic [DATA_W-1:0] fall_cap;
   logic              word_ok;
   logic              word_ok_d;

   assign word_ok = locked && strobe_edge;

   always_ff @(negedge clk) begin
      if (rst) fall_cap <= '0;
      else     fall_cap <= data_in;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rise_cap  <= '0;
         data_out  <= '0;
         word_ok_d <= 1'b0;
         valid     <= 1'b0;
      end else begin
         rise_cap  <= data_in;
         word_ok_d <= word_ok;
         data_out  <= pol_sel ? fall_cap : rise_cap;
         valid     <= pol_sel ? word_ok : word_ok_d;
      end
   end

endmodule

// File: rtl/strobe_pol_sel.sv
module strobe_pol_sel #(
   parameter int DATA_W      = 16,
   parameter int CODE_W      = 7,
   parameter int TIMEOUT_CYC = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_start,
   input  logic              strobe_lvl,
   input  logic              strobe_drv,
   input  logic              clk_phase_smp,
   input  logic [CODE_W-1:0] dly_code_in,
   input  logic [DATA_W-1:0] rd_data_in,
   output logic [CODE_W-1:0] dly_code_out,
   output logic              pol_sel,
   output logic              locked,
   output logic              timeout_err,
   output logic [DATA_W-1:0] rd_data_out,
   output logic              rd_valid
);

   generate
      if (DATA_W < 1)      begin : g_bad_data $error("DATA_W must be at least 1"); end
      if (CODE_W < 1)      begin : g_bad_code $error("CODE_W must be at least 1"); end
      if (TIMEOUT_CYC < 0) begin : g_bad_tmo  $error("TIMEOUT_CYC must not be negative"); end
   endgenerate

   logic pre_evt;
   logic strobe_edge;
   logic armed;

   assign dly_code_out = dly_code_in;

   sps_preamble_det u_det (
      .clk         (clk),
      .rst         (rst),
      .strobe_lvl  (strobe_lvl),
      .strobe_drv  (strobe_drv),
      .pre_evt     (pre_evt),
      .strobe_edge (strobe_edge)
   );

   sps_pol_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
      .clk           (clk),
      .rst           (rst),
      .rd_start      (rd_start),
      .pre_evt       (pre_evt),
      .strobe_drv    (strobe_drv),
      .clk_phase_smp (clk_phase_smp),
      .pol_sel       (pol_sel),
      .locked        (locked),
      .timeout_err   (timeout_err),
      .armed         (armed)
   );

   sps_xfer #(.DATA_W(DATA_W)) u_xfer (
      .clk         (clk),
      .rst         (rst),
      .pol_sel     (pol_sel),
      .locked      (locked),
      .strobe_edge (strobe_edge),
      .data_in     (rd_data_in),
      .data_out    (rd_data_out),
      .valid       (rd_valid)
   );

endmodule

// File: rtl/sps_checker.sv
module sps_checker (
   input logic clk,
   input logic rst,
   input logic rd_start,
   input logic pre_evt,
   input logic armed,
   input logic pol_sel,
   input logic locked,
   input logic timeout_err,
   input logic rd_valid
);

   // R5: the lock flag waits one cycle after the polarity update
   a_r5_no_instant_lock: assert property (@(posedge clk) disable iff (rst)
      (armed && pre_evt) |=> !locked);

   // R5: every lock rise traces back to an armed preamble two edges earlier
   a_r5_lock_from_event: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> $past(armed && pre_evt, 2));

   // R6: polarity frozen while locked
   a_r6_pol_frozen: assert property (@(posedge clk) disable iff (rst)
      locked |-> $stable(pol_sel));

   // R6: a start request during lock does not re-arm
   a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
      (locked && rd_start) |=> !armed);

   // R7: a timeout leaves the polarity untouched and no lock
   a_r7_tmo_keeps_pol: assert property (@(posedge clk) disable iff (rst)
      $rose(timeout_err) |-> ($stable(pol_sel) && !locked));

   // R8: valid words only come from a locked burst
   a_r8_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> ($past(locked) || $past(locked, 2)));

endmodule

bind strobe_pol_sel sps_checker u_chk (
   .clk         (clk),
   .rst         (rst),
   .rd_start    (rd_start),
   .pre_evt     (pre_evt),
   .armed       (armed),
   .pol_sel     (pol_sel),
   .locked      (locked),
   .timeout_err (timeout_err),
   .rd_valid    (rd_valid)
);

// File: tb/strobe_pol_sel_tb.sv
`timescale 1ns/1ps
module strobe_pol_sel_tb;

   localparam int DATA_W = 16;
   localparam int CODE_W = 7;
   localparam int TMO    = 32;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              rd_start = 1'b0;
   logic              strobe_lvl = 1'b1;
   logic              strobe_drv = 1'b0;
   logic              clk_phase_smp = 1'b0;
   logic [CODE_W-1:0] dly_code_in = '0;
   logic [DATA_W-1:0] rd_data_in = '0;
   logic [CODE_W-1:0] dly_code_out;
   logic              pol_sel, locked, timeout_err, rd_valid;
   logic [DATA_W-1:0] rd_data_out;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   strobe_pol_sel #(.DATA_W(DATA_W), .CODE_W(CODE_W), .TIMEOUT_CYC(TMO)) u_dut (
      .clk(clk), .rst(rst), .rd_start(rd_start), .strobe_lvl(strobe_lvl),
      .strobe_drv(strobe_drv), .clk_phase_smp(clk_phase_smp),
      .dly_code_in(dly_code_in), .rd_data_in(rd_data_in),
      .dly_code_out(dly_code_out), .pol_sel(pol_sel), .locked(locked),
      .timeout_err(timeout_err), .rd_data_out(rd_data_out), .rd_valid(rd_valid)
   );

   // expected-value model built from the requirements
   int              m_state;
   int              m_cnt;
   bit              m_pol, m_err, m_prev_lvl, m_prev_drv, m_v1, e_vld;
   bit [DATA_W-1:0] m_din_prev, e_out;

   function automatic bit exp_pol(input bit phase_high);
      return phase_high ? 1'b0 : 1'b1;   // R4
   endfunction

   function automatic bit is_preamble(input bit pd, input bit pl, input bit d, input bit l);
      return !pd && pl && d && !l;       // R3
   endfunction

   always @(posedge clk) begin
      bit cond;
      if (rst) begin
         m_state <= 0; m_cnt <= 0; m_pol <= 1'b0; m_err <= 1'b0;
         m_prev_lvl <= 1'b1; m_prev_drv <= 1'b0; m_v1 <= 1'b0;
         e_vld <= 1'b0; e_out <= '0; m_din_prev <= '0;
      end else begin
         cond = (m_state == 3) && strobe_drv && m_prev_drv && (strobe_lvl != m_prev_lvl);
         m_v1       <= cond;
         e_vld      <= m_pol ? cond : m_v1;
         e_out      <= m_pol ? rd_data_in : m_din_prev;
         m_din_prev <= rd_data_in;
         m_prev_lvl <= strobe_lvl;
         m_prev_drv <= strobe_drv;
         case (m_state)
            0: if (rd_start) begin m_state <= 1; m_cnt <= 0; m_err <= 1'b0; end
            1: if (is_preamble(m_prev_drv, m_prev_lvl, strobe_drv, strobe_lvl)) begin
                  m_pol <= exp_pol(clk_phase_smp); m_state <= 2;
               end else if (m_cnt == TMO - 1) begin
                  m_err <= 1'b1; m_state <= 0;
               end else m_cnt <= m_cnt + 1;
            2: m_state <= 3;
            default: if (!strobe_drv) m_state <= 0;
         endcase
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // continuous comparison away from the edges
   always begin
      @(posedge clk); #5;
      if (!rst && !done) begin
         chk("R4/R6 pol_sel", 32'(pol_sel), 32'(m_pol));
         chk("R5/R6 locked", 32'(locked), 32'(m_state == 3));
         chk("R7 timeout_err", 32'(timeout_err), 32'(m_err));
         chk("R8 rd_valid", 32'(rd_valid), 32'(e_vld));
         if (e_vld) chk("R9 rd_data_out", 32'(rd_data_out), 32'(e_out));
         chk("R2 dly_code_out", 32'(dly_code_out), 32'(dly_code_in));
      end
   end

   task automatic step(input bit rs, input bit drv, input bit lvl, input bit ph);
      rd_start      = rs;
      strobe_drv    = drv;
      strobe_lvl    = lvl;
      clk_phase_smp = ph;
      rd_data_in    = DATA_W'($urandom);
      dly_code_in   = CODE_W'($urandom);
      @(posedge clk); #1;
   endtask

   task automatic burst(input int idle_n, input bit ph, input int words);
      bit lvl = 1'b0;
      step(1'b1, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < idle_n; i++) step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b0, ph);                 // preamble (R3)
      step(1'b0, 1'b1, 1'b0, ~ph);
      for (int i = 0; i < words; i++) begin
         lvl = ~lvl;
         step(($urandom % 5) == 0, 1'b1, lvl, 1'b0); // stray starts (R6)
      end
      step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic stray(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b1, i[0], 1'b0);
      step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b0, 1'b1);               // drive-low while idle
      step(1'b0, 1'b0, 1'b1, 1'b0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #5;
      // R1: reset state
      chk("R1 pol_sel", 32'(pol_sel), 32'd0);
      chk("R1 locked", 32'(locked), 32'd0);
      chk("R1 timeout_err", 32'(timeout_err), 32'd0);
      chk("R1 rd_valid", 32'(rd_valid), 32'd0);
      @(posedge clk); #1;
      rst = 1'b0;

      // R10: strobe activity with no read request
      stray(6);
      chk("R10 locked idle", 32'(locked), 32'd0);
      chk("R10 pol idle", 32'(pol_sel), 32'd0);
      chk("R10 valid idle", 32'(rd_valid), 32'd0);

      // directed: falling capture then rising capture
      burst(2, 1'b0, 8);
      chk("R4 falling chosen", 32'(pol_sel), 32'd1);
      burst(0, 1'b1, 8);
      chk("R4 rising chosen", 32'(pol_sel), 32'd0);
      burst(1, 1'b0, 4);

      // R7: timeout keeps previous polarity (falling)
      step(1'b1, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < TMO + 2; i++) step(1'b0, 1'b0, 1'b1, 1'b0);
      #4;
      chk("R7 err raised", 32'(timeout_err), 32'd1);
      chk("R7 pol kept", 32'(pol_sel), 32'd1);
      burst(0, 1'b1, 3);
      chk("R7 err cleared", 32'(timeout_err), 32'd0);

      // random mix
      for (int k = 0; k < 60; k++) begin
         burst($urandom % 6, $urandom % 2, 2 + ($urandom % 11));
         if (($urandom % 4) == 0) stray(1 + ($urandom % 4));
      end
      @(posedge clk); #5;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule